// File: doc/BRIEF.md
# BCD clock calendar counter chain

This block keeps wall-clock time and the calendar date in packed BCD. It counts seconds, minutes and hours in 24-hour form. It also keeps a free-running day of the week, a date, a month, and a two-digit year with a century flag. A base tick input drives an internal prescaler. Every `TICKS_PER_SEC`-th tick that the block sees while running advances the seconds field. Each field carries into the next within the same clock cycle. The length of each month, including February in leap years, is computed from the current month and year.

A register-write port loads any field in parallel. A register-read port returns any field in parallel. A stop flag stored beside the seconds digits freezes the whole chain, prescaler included. Host logic sets the time by writing the fields. It reads the time back through the read port while the chain keeps running. Loaded values are taken as they are, so only legal BCD values give defined counting.

Top module: `rtc_cal_chain`

## Requirements
- R1: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count 00 to 59 in BCD. A step from 59 wraps the field to 00 and advances the next field in the same cycle.
- R2: Hours (address 2, bits 5:0) count 00 to 23 in BCD. The wrap from 23 to 00 advances both the date and the day of the week.
- R3: The day of the week (address 3, bits 2:0) counts 1 to 7 and returns to 1.
- R4: The date (address 4, bits 5:0) wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. The wrap advances the month.
- R5: In month 02 the date wraps after 29 when the BCD year is a multiple of 4 (00, 04, ... 96), and after 28 otherwise.
- R6: The month (address 5, bits 4:0) counts 01 to 12. Its wrap to 01 advances the year (address 6, bits 7:0), which counts 00 to 99 and wraps to 00.
- R7: Bit 7 of address 0 is a stop flag that reads back as written. While it is 1, no field and no prescaler state changes, except through writes.
- R8: Bit 7 of address 2 enables century counting and bit 6 is the century flag. Both read back as written. The century flag inverts on the year wrap from 99 to 00 only when the enable bit is 1.
- R9: The seconds field advances once for every `TICKS_PER_SEC` pulses on `tick_i` while running. Writing address 0 restarts this count from zero.
- R10: A write to a field in the same cycle as a carry into that field wins: the field takes the written value and gives no carry onward.
- R11: Address 7 always reads 0x00, and writes to it change no state.
- R12: After reset the fields read seconds 00, minutes 00, hours 00 with both century bits 0, day 1, date 01, month 01 and year 00, with the stop flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base tick, one-cycle pulse, `TICKS_PER_SEC` per second |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Field address for writes |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Field address for reads |
| rd_data_o | output | 8 | Read data for `rd_addr_i`, combinational |

## Verification
A table of preset dates, each advanced by exactly one second, is the main stimulus. Rows that change only the seconds units digit are set against rows that carry into the tens digit and rows that ripple through minute, hour and date. Month-end rows separate 31-day months, 30-day months, September rolling into a BCD month of 10, and February with leap and non-leap years. The non-leap years include 10, whose tens digit is odd. Directed cases then separate stopped from running time, a restarted prescaler from a free one, a write from a same-cycle carry, and century toggling with the enable set or clear.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    A_SEC   = 3'd0,
    A_MIN   = 3'd1,
    A_HOUR  = 3'd2,
    A_WDAY  = 3'd3,
    A_DATE  = 3'd4,
    A_MONTH = 3'd5,
    A_YEAR  = 3'd6,
    A_RSVD  = 3'd7
  } reg_addr_e;

  // BCD year mod 4 == (2*tens + ones) mod 4; only tens[0] and ones[1:0] matter
  function automatic logic [5:0] last_date(input logic [4:0] month,
                                           input logic       yr_tens_lsb,
                                           input logic [1:0] yr_ones_lo);
    logic [1:0] m4;
    m4 = {yr_tens_lsb, 1'b0} + yr_ones_lo;
    case (month)
      5'h02:                      last_date = (m4 == 2'd0) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
      default:                    last_date = 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic pulse_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step    = tick_i & run_i;
  assign pulse_o = step & ~clr_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (step)         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field #(
  parameter int           W     = 7,
  parameter logic [W-1:0] FIRST = '0,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  localparam int HW = (W > 4) ? W - 4 : 1;

  logic [W-1:0] val_q, inc_val;
  logic         at_last;

  generate
    if (W > 4) begin : g_two_digit
      always_comb begin
        if (val_q[3:0] == 4'd9) inc_val = {val_q[W-1:4] + HW'(1), 4'd0};
        else                    inc_val = {val_q[W-1:4], val_q[3:0] + 4'd1};
      end
    end else begin : g_one_digit
      always_comb inc_val = val_q + W'(1);
    end
  endgenerate

  assign at_last = (val_q == last_i);
  assign wrap_o  = inc_i & ~ld_i & at_last;  // a load swallows the carry
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST;
    else if (ld_i)   val_q <= ld_val_i;
    else if (inc_i)  val_q <= at_last ? FIRST : inc_val;
  end
endmodule

// File: rtl/rtc_cal_chain.sv
`timescale 1ns/1ps
module rtc_cal_chain
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o
);
  logic ld_sec, ld_min, ld_hour, ld_wday, ld_date, ld_month, ld_year;
  logic stop_q, ceb_q, cb_q;
  logic sec_pulse;
  logic sec_wrap, min_wrap, hour_wrap, wday_wrap, date_wrap, month_wrap, year_wrap;
  logic [6:0] sec_q, min_q;
  logic [5:0] hour_q, date_q, date_last;
  logic [2:0] wday_q;
  logic [4:0] month_q;
  logic [7:0] year_q;

  assign ld_sec   = wr_en_i && (wr_addr_i == A_SEC);
  assign ld_min   = wr_en_i && (wr_addr_i == A_MIN);
  assign ld_hour  = wr_en_i && (wr_addr_i == A_HOUR);
  assign ld_wday  = wr_en_i && (wr_addr_i == A_WDAY);
  assign ld_date  = wr_en_i && (wr_addr_i == A_DATE);
  assign ld_month = wr_en_i && (wr_addr_i == A_MONTH);
  assign ld_year  = wr_en_i && (wr_addr_i == A_YEAR);

  rtc_prescaler #(.DIV(TICKS_PER_SEC)) u_presc (
    .clk_i, .rst_ni, .tick_i, .run_i(~stop_q), .clr_i(ld_sec), .pulse_o(sec_pulse)
  );

  rtc_bcd_field #(.W(7)) u_sec (
    .clk_i, .rst_ni, .ld_i(ld_sec), .ld_val_i(wr_data_i[6:0]), .inc_i(sec_pulse),
    .last_i(7'h59), .val_o(sec_q), .wrap_o(sec_wrap)
  );

  rtc_bcd_field #(.W(7)) u_min (
    .clk_i, .rst_ni, .ld_i(ld_min), .ld_val_i(wr_data_i[6:0]), .inc_i(sec_wrap),
    .last_i(7'h59), .val_o(min_q), .wrap_o(min_wrap)
  );

  rtc_bcd_field #(.W(6)) u_hour (
    .clk_i, .rst_ni, .ld_i(ld_hour), .ld_val_i(wr_data_i[5:0]), .inc_i(min_wrap),
    .last_i(6'h23), .val_o(hour_q), .wrap_o(hour_wrap)
  );

  rtc_bcd_field #(.W(3), .FIRST(3'd1), .RST(3'd1)) u_wday (
    .clk_i, .rst_ni, .ld_i(ld_wday), .ld_val_i(wr_data_i[2:0]), .inc_i(hour_wrap),
    .last_i(3'd7), .val_o(wday_q), .wrap_o(wday_wrap)
  );

  assign date_last = last_date(month_q, year_q[4], year_q[1:0]);

  rtc_bcd_field #(.W(6), .FIRST(6'h01), .RST(6'h01)) u_date (
    .clk_i, .rst_ni, .ld_i(ld_date), .ld_val_i(wr_data_i[5:0]), .inc_i(hour_wrap),
    .last_i(date_last), .val_o(date_q), .wrap_o(date_wrap)
  );

  rtc_bcd_field #(.W(5), .FIRST(5'h01), .RST(5'h01)) u_month (
    .clk_i, .rst_ni, .ld_i(ld_month), .ld_val_i(wr_data_i[4:0]), .inc_i(date_wrap),
    .last_i(5'h12), .val_o(month_q), .wrap_o(month_wrap)
  );

  rtc_bcd_field #(.W(8)) u_year (
    .clk_i, .rst_ni, .ld_i(ld_year), .ld_val_i(wr_data_i), .inc_i(month_wrap),
    .last_i(8'h99), .val_o(year_q), .wrap_o(year_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      ceb_q  <= 1'b0;
      cb_q   <= 1'b0;
    end else begin
      if (ld_sec) stop_q <= wr_data_i[7];
      if (ld_hour) begin
        ceb_q <= wr_data_i[7];
        cb_q  <= wr_data_i[6];
      end else if (year_wrap && ceb_q) begin
        cb_q  <= ~cb_q;
      end
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_SEC:   rd_data_o = {stop_q, sec_q};
      A_MIN:   rd_data_o = {1'b0, min_q};
      A_HOUR:  rd_data_o = {ceb_q, cb_q, hour_q};
      A_WDAY:  rd_data_o = {5'd0, wday_q};
      A_DATE:  rd_data_o = {2'd0, date_q};
      A_MONTH: rd_data_o = {3'd0, month_q};
      A_YEAR:  rd_data_o = year_q;
      default: rd_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_cal_chain_chk.sv
`timescale 1ns/1ps
module rtc_cal_chain_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       sec_pulse,
  input logic       stop_q,
  input logic [6:0] sec_q,
  input logic [6:0] min_q,
  input logic [5:0] hour_q,
  input logic [2:0] wday_q,
  input logic       wday_wrap,
  input logic       ceb_q,
  input logic       cb_q
);
  AST_SEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q[3:0] <= 4'd9) && (sec_q[6:4] <= 3'd5)); // R1

  AST_HOUR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hour_q[3:0] <= 4'd9) && (hour_q <= 6'h23)); // R2

  AST_WDAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wday_wrap |=> (wday_q == 3'd1)); // R3

  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(wday_q))); // R7

  AST_CB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ceb_q && !(wr_en_i && wr_addr_i == 3'd2)) |=> $stable(cb_q)); // R8

  AST_SEC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse && !(wr_en_i && wr_addr_i == 3'd0)) |=> (sec_q != $past(sec_q))); // R9

  AST_SEC_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0) |=> (sec_q == $past(wr_data_i[6:0]))); // R10
endmodule

bind rtc_cal_chain rtc_cal_chain_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .sec_pulse(sec_pulse), .stop_q(stop_q), .sec_q(sec_q),
  .min_q(min_q), .hour_q(hour_q), .wday_q(wday_q), .wday_wrap(wday_wrap),
  .ceb_q(ceb_q), .cb_q(cb_q)
);

// File: tb/rtc_cal_chain_tb_top.sv
`timescale 1ns/1ps
module rtc_cal_chain_tb_top;
  localparam int TPS = 4;
  localparam int NV  = 17;

  // per row: sec,min,hour,wday,date,month,year preset | expected one second later
  localparam logic [7:0] VEC [NV][14] = '{
    '{8'h12,8'h34,8'h15,8'h3,8'h10,8'h06,8'h24, 8'h13,8'h34,8'h15,8'h3,8'h10,8'h06,8'h24}, // R1
    '{8'h59,8'h10,8'h08,8'h2,8'h05,8'h05,8'h05, 8'h00,8'h11,8'h08,8'h2,8'h05,8'h05,8'h05}, // R1
    '{8'h09,8'h59,8'h08,8'h2,8'h05,8'h05,8'h05, 8'h10,8'h59,8'h08,8'h2,8'h05,8'h05,8'h05}, // R1
    '{8'h59,8'h59,8'h09,8'h4,8'h12,8'h07,8'h30, 8'h00,8'h00,8'h10,8'h4,8'h12,8'h07,8'h30}, // R2
    '{8'h59,8'h59,8'h23,8'h7,8'h15,8'h03,8'h25, 8'h00,8'h00,8'h00,8'h1,8'h16,8'h03,8'h25}, // R2 R3
    '{8'h59,8'h59,8'h23,8'h2,8'h30,8'h04,8'h25, 8'h00,8'h00,8'h00,8'h3,8'h01,8'h05,8'h25}, // R4
    '{8'h59,8'h59,8'h23,8'h5,8'h31,8'h01,8'h25, 8'h00,8'h00,8'h00,8'h6,8'h01,8'h02,8'h25}, // R4
    '{8'h59,8'h59,8'h23,8'h1,8'h30,8'h09,8'h25, 8'h00,8'h00,8'h00,8'h2,8'h01,8'h10,8'h25}, // R4
    '{8'h59,8'h59,8'h23,8'h1,8'h30,8'h10,8'h25, 8'h00,8'h00,8'h00,8'h2,8'h31,8'h10,8'h25}, // R4
    '{8'h59,8'h59,8'h23,8'h3,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h4,8'h01,8'h03,8'h23}, // R5
    '{8'h59,8'h59,8'h23,8'h3,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h4,8'h29,8'h02,8'h24}, // R5
    '{8'h59,8'h59,8'h23,8'h3,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h4,8'h01,8'h03,8'h24}, // R5
    '{8'h59,8'h59,8'h23,8'h3,8'h28,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h4,8'h29,8'h02,8'h00}, // R5
    '{8'h59,8'h59,8'h23,8'h3,8'h28,8'h02,8'h10, 8'h00,8'h00,8'h00,8'h4,8'h01,8'h03,8'h10}, // R5
    '{8'h59,8'h59,8'h23,8'h3,8'h28,8'h02,8'h12, 8'h00,8'h00,8'h00,8'h4,8'h29,8'h02,8'h12}, // R5
    '{8'h59,8'h59,8'h23,8'h6,8'h31,8'h12,8'h19, 8'h00,8'h00,8'h00,8'h7,8'h01,8'h01,8'h20}, // R6
    '{8'h59,8'h59,8'h23,8'h6,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h7,8'h01,8'h01,8'h00}  // R6
  };

  function automatic string vtag(input int v);
    if (v < 3)       return "R1";
    else if (v < 5)  return "R2";
    else if (v < 9)  return "R4";
    else if (v < 15) return "R5";
    else             return "R6";
  endfunction

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_cal_chain #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_addr = a; #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d: actual %02h expected %02h", tag, a, rd_data, exp);
    end
  endtask

  task automatic set_end_of_century(input logic [7:0] hour);
    wr(3'd2, hour); wr(3'd3, 8'h1); wr(3'd4, 8'h31); wr(3'd5, 8'h12);
    wr(3'd6, 8'h99); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset values
    chk(3'd0, 8'h00, "R12"); chk(3'd1, 8'h00, "R12"); chk(3'd2, 8'h00, "R12");
    chk(3'd3, 8'h01, "R12"); chk(3'd4, 8'h01, "R12"); chk(3'd5, 8'h01, "R12");
    chk(3'd6, 8'h00, "R12");

    // R11 reserved address
    wr(3'd7, 8'hFF);
    chk(3'd7, 8'h00, "R11"); chk(3'd0, 8'h00, "R11"); chk(3'd2, 8'h00, "R11");

    for (int v = 0; v < NV; v++) begin
      for (int f = 0; f < 7; f++) wr(3'(f), VEC[v][f]);
      ticks(TPS);
      for (int f = 0; f < 7; f++) chk(3'(f), VEC[v][7+f], vtag(v));
    end

    // R7 stop flag
    wr(3'd0, 8'h85); ticks(2 * TPS);
    chk(3'd0, 8'h85, "R7");
    wr(3'd0, 8'h05); ticks(TPS);
    chk(3'd0, 8'h06, "R7");

    // R9 prescaler division and restart
    wr(3'd0, 8'h10); ticks(TPS - 1);
    chk(3'd0, 8'h10, "R9");
    ticks(1);
    chk(3'd0, 8'h11, "R9");
    ticks(TPS - 1); wr(3'd0, 8'h20); ticks(TPS - 1);
    chk(3'd0, 8'h20, "R9");
    ticks(1);
    chk(3'd0, 8'h21, "R9");

    // R10 write beats same-cycle carry
    wr(3'd1, 8'h10); wr(3'd0, 8'h59); ticks(TPS - 1);
    wr_tick(3'd1, 8'h42);
    chk(3'd0, 8'h00, "R10"); chk(3'd1, 8'h42, "R10");
    wr(3'd0, 8'h30); ticks(TPS - 1);
    wr_tick(3'd0, 8'h07);
    chk(3'd0, 8'h07, "R10");

    // R8 century flag
    set_end_of_century(8'hA3); ticks(TPS);
    chk(3'd2, 8'hC0, "R8"); chk(3'd6, 8'h00, "R8");
    set_end_of_century(8'h63); ticks(TPS);
    chk(3'd2, 8'h40, "R8");
    set_end_of_century(8'hE3); ticks(TPS);
    chk(3'd2, 8'h80, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule